// File: doc/BRIEF.md
# Ramped PWM Output Ports

This block drives a small group of general output pins. Each pin is either a plain static level or a pulse-width modulated waveform with a duty of 0 to 127 out of a 128-tick period. One counter runs the period for all channels, so every channel starts its period on the same clock.

Software does not jump the duty straight to a new value. It stages a target duty and a slope code for each channel, then issues an execute command with a channel mask. From then on the live duty of each selected channel moves toward its target. It moves one step every few periods, or it jumps straight to the target when the slope code is zero. A duty value changes only on the clock where the period wraps, so no period ever carries a cut-short or stretched pulse.

The highest-numbered port can be handed to a key scan circuit. While that is selected, the pin's output enable is dropped and its data is held low.

Top module: `gpo_pwm_ramp`

## Requirements
- R1: During reset and right after it, every port output is low and every enable is high (except a port released by R8). Every channel is in static mode with level 0, with live duty 0 and staged target and slope 0.
- R2: The period is 128 clocks from one shared counter that counts from 0 to 127 and wraps. A channel in PWM mode outputs high while the counter is below its live duty, so a duty of 127 gives 127 high clocks in each period.
- R3: A channel in PWM mode with live duty 0 outputs a constant low.
- R4: A staged target or slope has no effect on a channel's ramp until an execute command with that channel's mask bit set. The execute copies both staged values into the live ramp settings and clears the channel's period count.
- R5: After execute with slope code k>0, the live duty moves one step toward the target on every k-th period boundary. With k=0 it takes the target value at the next boundary. Once the duty equals the target it stays there.
- R6: A channel whose mode bit is 0 outputs its static level bit in every clock, whatever its duty or ramp state.
- R7: A live duty changes only on the clock where the counter wraps from 127 to 0. An execute in the middle of a period leaves that period's waveform unchanged.
- R8: While `keyscan_sel` is high, the last port has its enable low and its output low. The other ports are unaffected.
- R9: Command encoding when `wr_en` is high, one command per clock:
  - `wr_cmd`=0 loads the static levels from `wr_data[3:0]` and the mode bits from `wr_data[7:4]` (1 = PWM), bit i for channel i.
  - `wr_cmd`=1 stages target `wr_data[6:0]` for channel `wr_ch`.
  - `wr_cmd`=2 stages slope `wr_data[3:0]` for channel `wr_ch`.
  - `wr_cmd`=3 executes for the channels set in `wr_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one PWM tick per clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command strobe, one command per clock |
| wr_cmd | input | 2 | Command code (R9) |
| wr_ch | input | 2 | Channel index for the target and slope commands |
| wr_data | input | 8 | Command operand |
| keyscan_sel | input | 1 | Hands the last port to key scan |
| port_out | output | 4 | Port data, bit i for channel i |
| port_oe | output | 4 | Port output enables |

## Verification
The assertions assume that `rst_n` is held low until the first clock edge and that at most one command arrives per clock. They also assume the block sees each execute mask only in the clock it is written. The bench drives every input on the falling edge and keeps `wr_en` to a single command per clock. It resets the design at the start, so all properties start from a known state. The random phase draws any command code, channel and operand, including slopes of zero and targets both above and below the live duty. It toggles the key scan select only rarely, so that ramps run across many periods.

// File: rtl/gpo_pwm_pkg.sv
package gpo_pwm_pkg;
  localparam int DUTY_W  = 7;
  localparam int SLOPE_W = 4;
  localparam int PERIOD  = 1 << DUTY_W;

  typedef logic [DUTY_W-1:0]  duty_t;
  typedef logic [SLOPE_W-1:0] slope_t;

  typedef enum logic [1:0] {
    CMD_STATIC = 2'd0,
    CMD_TARGET = 2'd1,
    CMD_SLOPE  = 2'd2,
    CMD_EXEC   = 2'd3
  } gpo_cmd_e;

  // waveform level for one tick of the period
  function automatic logic pwm_high(duty_t tick, duty_t duty);
    return tick < duty;
  endfunction

  // one unit toward the target, or unchanged when already there
  function automatic duty_t step_toward(duty_t cur, duty_t tgt);
    if (cur < tgt) return cur + duty_t'(1);
    if (cur > tgt) return cur - duty_t'(1);
    return cur;
  endfunction

  // true when this boundary is the one on which a step is taken
  function automatic logic step_due(slope_t slope, slope_t div);
    return (slope == '0) || (div == slope - slope_t'(1));
  endfunction
endpackage

// File: rtl/gpo_pwm_timebase.sv
module gpo_pwm_timebase
  import gpo_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output duty_t cnt,
  output logic  boundary
);
  localparam duty_t LAST = duty_t'(PERIOD - 1);

  assign boundary = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + duty_t'(1);
  end
endmodule

// File: rtl/gpo_pwm_cmd.sv
module gpo_pwm_cmd
  import gpo_pwm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_cmd,
  input  logic [1:0]                     wr_ch,
  input  logic [7:0]                     wr_data,
  output logic [NCH-1:0]                 lvl,
  output logic [NCH-1:0]                 mode,
  output logic [NCH-1:0][DUTY_W-1:0]     stg_tgt,
  output logic [NCH-1:0][SLOPE_W-1:0]    stg_slope,
  output logic [NCH-1:0]                 exec_mask
);
  localparam int MODE_LSB = 4;

  logic is_static, is_target, is_slope, is_exec;

  assign is_static = wr_en && (wr_cmd == CMD_STATIC);
  assign is_target = wr_en && (wr_cmd == CMD_TARGET);
  assign is_slope  = wr_en && (wr_cmd == CMD_SLOPE);
  assign is_exec   = wr_en && (wr_cmd == CMD_EXEC);

  assign exec_mask = is_exec ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl  <= '0;
      mode <= '0;
    end else if (is_static) begin
      lvl  <= wr_data[NCH-1:0];
      mode <= wr_data[MODE_LSB +: NCH];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_stage
    logic hit;
    assign hit = (wr_ch == 2'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_tgt[i]   <= '0;
        stg_slope[i] <= '0;
      end else begin
        if (is_target && hit) stg_tgt[i]   <= wr_data[DUTY_W-1:0];
        if (is_slope  && hit) stg_slope[i] <= wr_data[SLOPE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gpo_pwm_ramp_ch.sv
module gpo_pwm_ramp_ch
  import gpo_pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   boundary,
  input  logic   exec,
  input  duty_t  stg_tgt,
  input  slope_t stg_slope,
  output duty_t  duty,
  output duty_t  act_tgt,
  output slope_t act_slope,
  output logic   step_ev
);
  slope_t div;
  logic   moving;

  assign moving  = (duty != act_tgt);
  assign step_ev = boundary && !exec && moving && step_due(act_slope, div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty      <= '0;
      act_tgt   <= '0;
      act_slope <= '0;
      div       <= '0;
    end else if (exec) begin
      act_tgt   <= stg_tgt;
      act_slope <= stg_slope;
      div       <= '0;
    end else if (boundary) begin
      if (!moving) begin
        div <= '0;
      end else if (act_slope == '0) begin
        duty <= act_tgt;
        div  <= '0;
      end else if (step_due(act_slope, div)) begin
        duty <= step_toward(duty, act_tgt);
        div  <= '0;
      end else begin
        div <= div + slope_t'(1);
      end
    end
  end
endmodule

// File: rtl/gpo_pwm_ramp.sv
module gpo_pwm_ramp
  import gpo_pwm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int KS_PORT = NCH - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_cmd,
  input  logic [1:0]     wr_ch,
  input  logic [7:0]     wr_data,
  input  logic           keyscan_sel,
  output logic [NCH-1:0] port_out,
  output logic [NCH-1:0] port_oe
);
  duty_t                      cnt;
  logic                       boundary;
  logic [NCH-1:0]             lvl, mode, exec_mask, step_ev;
  logic [NCH-1:0][DUTY_W-1:0]  stg_tgt, duty_v, act_tgt;
  logic [NCH-1:0][SLOPE_W-1:0] stg_slope, act_slope;

  gpo_pwm_timebase u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .boundary (boundary)
  );

  gpo_pwm_cmd #(.NCH(NCH)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_cmd    (wr_cmd),
    .wr_ch     (wr_ch),
    .wr_data   (wr_data),
    .lvl       (lvl),
    .mode      (mode),
    .stg_tgt   (stg_tgt),
    .stg_slope (stg_slope),
    .exec_mask (exec_mask)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wave, released;

    gpo_pwm_ramp_ch u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .exec      (exec_mask[i]),
      .stg_tgt   (stg_tgt[i]),
      .stg_slope (stg_slope[i]),
      .duty      (duty_v[i]),
      .act_tgt   (act_tgt[i]),
      .act_slope (act_slope[i]),
      .step_ev   (step_ev[i])
    );

    if (i == KS_PORT) begin : g_shared
      assign released = keyscan_sel;
    end else begin : g_own
      assign released = 1'b0;
    end

    assign wave        = mode[i] ? pwm_high(cnt, duty_v[i]) : lvl[i];
    assign port_out[i] = wave && !released;
    assign port_oe[i]  = !released;
  end
endmodule

// File: rtl/gpo_pwm_ramp_chk.sv
module gpo_pwm_ramp_chk
  import gpo_pwm_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int KS_PORT = NCH - 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input duty_t                       cnt,
  input logic                        boundary,
  input logic [NCH-1:0]              mode,
  input logic [NCH-1:0]              exec_mask,
  input logic [NCH-1:0]              step_ev,
  input logic [NCH-1:0][DUTY_W-1:0]  duty_v,
  input logic [NCH-1:0][DUTY_W-1:0]  act_tgt,
  input logic                        keyscan_sel,
  input logic [NCH-1:0]              port_out,
  input logic [NCH-1:0]              port_oe
);
  // R2: the shared counter wraps to zero after the boundary tick
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));

  // R2: otherwise it advances by one each clock
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> (cnt == $past(cnt) + duty_t'(1)));

  // R8: the shared port is let go while key scan owns it
  p_port_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    keyscan_sel |-> (!port_oe[KS_PORT] && !port_out[KS_PORT]));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R3: zero duty keeps a PWM channel low
    p_zero_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] && duty_v[i] == '0) |-> !port_out[i]);

    // R7: the live duty is frozen away from the wrap clock
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(duty_v[i]));

    // R4: the ramp target is only replaced by execute
    p_exec_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_mask[i] |=> $stable(act_tgt[i]));

    // R5: a step event moves the duty
    p_step_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step_ev[i] |=> (duty_v[i] != $past(duty_v[i])));

    // R5: a ramp never overshoots its target
    p_no_overshoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ev[i] && duty_v[i] < act_tgt[i]) |=> (duty_v[i] <= $past(act_tgt[i])));
  end
endmodule

bind gpo_pwm_ramp gpo_pwm_ramp_chk #(.NCH(NCH), .KS_PORT(KS_PORT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt         (cnt),
  .boundary    (boundary),
  .mode        (mode),
  .exec_mask   (exec_mask),
  .step_ev     (step_ev),
  .duty_v      (duty_v),
  .act_tgt     (act_tgt),
  .keyscan_sel (keyscan_sel),
  .port_out    (port_out),
  .port_oe     (port_oe)
);

// File: tb/gpo_pwm_ramp_bench.sv
module gpo_pwm_ramp_bench;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int TICKS = 128;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_cmd = '0;
  logic [1:0]     wr_ch = '0;
  logic [7:0]     wr_data = '0;
  logic           keyscan_sel = 1'b0;
  logic [NCH-1:0] port_out, port_oe;

  always #(CLK_P/2) clk = ~clk;

  gpo_pwm_ramp #(.NCH(NCH)) u_gpo_pwm_ramp (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_cmd (wr_cmd),
    .wr_ch (wr_ch), .wr_data (wr_data), .keyscan_sel (keyscan_sel),
    .port_out (port_out), .port_oe (port_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  // reference state, restated from the requirements
  int       m_cnt;
  int       m_duty [NCH];
  int       m_goal [NCH];
  int       m_rate [NCH];
  int       m_seen [NCH];
  int       s_goal [NCH];
  int       s_rate [NCH];
  logic [3:0] m_lvl, m_pwm;
  bit       wrap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lvl = '0; m_pwm = '0;
      for (int i = 0; i < NCH; i++) begin
        m_duty[i] = 0; m_goal[i] = 0; m_rate[i] = 0; m_seen[i] = 0;
        s_goal[i] = 0; s_rate[i] = 0;
      end
    end else begin
      wrap = (m_cnt == TICKS - 1);
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && wr_cmd == 2'd3 && wr_data[i]) begin
          m_goal[i] = s_goal[i]; m_rate[i] = s_rate[i]; m_seen[i] = 0;
        end else if (wrap) begin
          if (m_duty[i] == m_goal[i]) m_seen[i] = 0;
          else if (m_rate[i] == 0) m_duty[i] = m_goal[i];
          else begin
            m_seen[i]++;
            if (m_seen[i] == m_rate[i]) begin
              m_seen[i] = 0;
              m_duty[i] += (m_goal[i] > m_duty[i]) ? 1 : -1;
            end
          end
        end
      end
      if (wr_en) begin
        case (wr_cmd)
          2'd0: begin m_lvl = wr_data[3:0]; m_pwm = wr_data[7:4]; end
          2'd1: s_goal[wr_ch] = int'(wr_data[6:0]);
          2'd2: s_rate[wr_ch] = int'(wr_data[3:0]);
          default: ;
        endcase
      end
      m_cnt = (m_cnt + 1) % TICKS;
    end
  end

  function automatic logic exp_bit(int i);
    if (i == NCH - 1 && keyscan_sel) return 1'b0;
    if (m_pwm[i]) return (m_cnt < m_duty[i]);
    return m_lvl[i];
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference (R2, R6, R8)
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      logic [3:0] eo, ee;
      for (int i = 0; i < NCH; i++) begin
        eo[i] = exp_bit(i);
        ee[i] = !(i == NCH - 1 && keyscan_sel);
      end
      checks++;
      if (port_out !== eo || port_oe !== ee) begin
        fails++;
        $display("FAIL R2/R6/R8 model at tick %0d: got out=%b oe=%b expected out=%b oe=%b",
                 m_cnt, port_out, port_oe, eo, ee);
      end
    end
  end

  task automatic wr(input logic [1:0] cmd, input logic [1:0] ch, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = cmd; wr_ch = ch; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    do begin @(negedge clk); #1; end while (m_cnt != v);
  endtask

  // high clocks of one channel over one full period, from tick 0
  task automatic measure(input int ch, output int c);
    c = 0;
    wait_cnt(0);
    for (int k = 0; k < TICKS; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      c += int'(port_out[ch]);
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    int seq [6] = '{64, 65, 65, 66, 66, 67};
    void'($urandom(32'd2718));

    repeat (3) @(negedge clk);
    #1;
    chk("R1 out in reset", int'(port_out), 0);
    chk("R1 oe in reset", int'(port_oe), 15);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 out after reset", int'(port_out), 0);
    chk("R1 oe after reset", int'(port_oe), 15);
    cmp_on = 1'b1;

    // R9 static command: ch0, ch1 PWM; ch2 static high; ch3 static low
    wr(2'd0, 2'd0, 8'b0011_0100);
    wr(2'd1, 2'd0, 8'd64);
    measure(0, c); chk("R4 staged target without execute", c, 0);
    measure(2, c); chk("R6 static high level", c, 128);
    measure(3, c); chk("R6 static low level", c, 0);

    wr(2'd2, 2'd0, 8'd0);
    wr(2'd3, 2'd0, 8'h1);
    measure(0, c); chk("R5 slope zero jump", c, 64);

    // R5 ramp 64 -> 67 with one step every second boundary
    wr(2'd1, 2'd0, 8'd67);
    wr(2'd2, 2'd0, 8'd2);
    wait_cnt(9);
    wr(2'd3, 2'd0, 8'h1);
    for (int p = 0; p < 6; p++) begin
      measure(0, c); chk("R5 ramp period", c, seq[p]);
    end
    measure(0, c); chk("R5 holds at target", c, 67);

    // R7 execute mid-period leaves that period untouched
    wr(2'd1, 2'd1, 8'd100);
    wr(2'd2, 2'd1, 8'd0);
    wait_cnt(127);
    fork
      measure(1, c);
      begin wait_cnt(49); wr(2'd3, 2'd0, 8'h2); end
    join
    chk("R7 period holding the execute", c, 0);
    measure(1, c); chk("R7 new duty from next period", c, 100);

    wr(2'd1, 2'd1, 8'd127); wr(2'd3, 2'd0, 8'h2);
    measure(1, c); chk("R2 duty 127", c, 127);
    wr(2'd1, 2'd1, 8'd0); wr(2'd3, 2'd0, 8'h2);
    measure(1, c); chk("R3 duty 0 low", c, 0);

    // R6 ramp on a static channel does not reach its pin
    wr(2'd1, 2'd2, 8'd90); wr(2'd3, 2'd0, 8'h4);
    measure(2, c); measure(2, c); chk("R6 static ignores duty", c, 128);

    // R8 shared port hand-over
    wr(2'd0, 2'd0, 8'b1011_0100);
    wr(2'd1, 2'd3, 8'd64); wr(2'd2, 2'd3, 8'd0); wr(2'd3, 2'd0, 8'h8);
    @(negedge clk); keyscan_sel = 1'b1;
    measure(3, c); chk("R8 released port low", c, 0);
    chk("R8 enables", int'(port_oe), 7);
    @(negedge clk); keyscan_sel = 1'b0;
    measure(3, c); chk("R8 port back in use", c, 64);

    // random commands, checked by the per-clock comparison
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) begin
        wr_en = 1'b1; wr_cmd = 2'($urandom); wr_ch = 2'($urandom);
        wr_data = 8'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      if ($urandom % 400 == 0) keyscan_sel = ~keyscan_sel;
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule